// File: doc/BRIEF.md
# Switch-Selected LED Pattern Sequencer

The block drives eight LEDs with a repeating sequence of patterns. A 2-bit mode input selects one of four sequences:

- two alternating pairs of patterns;
- a single lit LED walking toward the high bit;
- a single lit LED walking toward the low bit.

A free-running prescaler on the system clock sets the step rate. A full-size prescaler makes each pattern last long enough for a person to see it.

All logic runs on the one system clock. The prescaler does not make a derived clock. Instead it gives a one-cycle step enable on each rising edge of its top bit. The sequencer changes state only in a cycle where that enable is high.

The sequencer holds the mode it is showing. It compares that held mode with the input only at a step. If they differ, it restarts at the first pattern of the new mode. Because the comparison is made only at a step, the mode input may change freely between steps.

Top module: `led_pattern_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the prescaler clears and `led_o` takes the first pattern of the mode on `mode_i` (8'h33, 8'h01, 8'h80 or 8'h81 for modes 00, 01, 10, 11).
- R2: With prescaler width W, `led_o` first changes at the (2^(W-1)+1)-th clock edge after reset is released. After that it changes every 2^W edges. The internal step enable is never high for two cycles in a row.
- R3: Mode 00 alternates 8'h33, 8'hCC, starting from 8'h33.
- R4: Mode 01 shows 8'h01, 8'h02, ... 8'h80: one lit LED that moves one place toward the high bit per step.
- R5: Mode 10 shows 8'h80, 8'h40, ... 8'h01: one lit LED that moves one place toward the low bit per step.
- R6: Mode 11 alternates 8'h81, 8'h18, starting from 8'h81.
- R7: After the last pattern of a mode, the next step shows that mode's first pattern again.
- R8: `led_o` holds its value between steps, whatever `mode_i` does. At a step where `mode_i` differs from the mode being shown, `led_o` becomes the first pattern of the new mode. A change that is undone before the step has no effect.

`mode_i[0]` is the low select bit and `mode_i[1]` is the high select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Sequence select |
| led_o | output | 8 | LED drive, bit 7 is the leftmost LED |

## Verification
A wrong prescaler count shows at the ports as a pattern change one or more cycles away from the predicted edge. The bench therefore samples one cycle before each expected change and again at the change itself. A corrupted pattern index or held mode shows within one step: the bench would see a wrong pattern, a skipped wrap, or a missing restart. Every step is compared with a value the bench computed on its own. A mode change that is undone mid-period exposes any sequencer that samples `mode_i` outside the step cycle.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  localparam int LED_W = 8;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    MODE_PAIR_A  = 2'b00,
    MODE_WALK_UP = 2'b01,
    MODE_WALK_DN = 2'b10,
    MODE_PAIR_B  = 2'b11
  } seq_mode_e;

  function automatic logic [IDX_W-1:0] last_idx(input seq_mode_e m);
    case (m)
      MODE_WALK_UP, MODE_WALK_DN: last_idx = IDX_W'(LED_W - 1);
      default:                    last_idx = IDX_W'(1);
    endcase
  endfunction

  function automatic logic [LED_W-1:0] pattern(input seq_mode_e m,
                                               input logic [IDX_W-1:0] idx);
    case (m)
      MODE_PAIR_A:  pattern = idx[0] ? 8'hCC : 8'h33;
      MODE_WALK_UP: pattern = 8'h01 << idx;
      MODE_WALK_DN: pattern = 8'h80 >> idx;
      default:      pattern = idx[0] ? 8'h18 : 8'h81;
    endcase
  endfunction
endpackage

// File: rtl/led_seq_prescaler.sv
module led_seq_prescaler #(
  parameter int CNT_W = 27
) (
  input  logic clk,
  input  logic rst,
  output logic step_o
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             msb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      msb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      msb_q <= cnt_q[MSB];
    end
  end

  assign step_o = cnt_q[MSB] & ~msb_q;

  // R2: the step enable lasts exactly one cycle
  p_step_single_r2: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);
endmodule

// File: rtl/led_seq_stepper.sv
module led_seq_stepper
  import led_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [1:0]       mode_i,
  output logic [LED_W-1:0] led_o
);
  seq_mode_e        mode_q;
  seq_mode_e        mode_in;
  logic [IDX_W-1:0] idx_q;

  assign mode_in = seq_mode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_in;
      idx_q  <= '0;
    end else if (step_i) begin
      if (mode_in != mode_q) begin
        mode_q <= mode_in;
        idx_q  <= '0;
      end else if (idx_q == last_idx(mode_q)) begin
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign led_o = pattern(mode_q, idx_q);

  // R8: output holds between steps
  p_hold_no_step_r8: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(led_o));

  // R8: a mode change seen at a step restarts at index zero
  p_restart_on_change_r8: assert property (@(posedge clk) disable iff (rst)
    (step_i && mode_in != mode_q) |=> (idx_q == '0));

  // R7: the last pattern wraps to the first
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i && mode_in == mode_q && idx_q == last_idx(mode_q)) |=> (idx_q == '0));

  // R4, R5: walking modes light exactly one LED
  p_single_lit_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WALK_UP || mode_q == MODE_WALK_DN) |-> $countones(led_o) == 1);
endmodule

// File: rtl/led_pattern_seq.sv
module led_pattern_seq
  import led_seq_pkg::*;
#(
  parameter int PRESCALE_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  output logic [LED_W-1:0] led_o
);
  logic step;

  led_seq_prescaler #(.CNT_W(PRESCALE_W)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .step_o (step)
  );

  led_seq_stepper u_stepper (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .mode_i (mode_i),
    .led_o  (led_o)
  );

  // R1: the cycle after reset shows a first pattern
  p_reset_first_r1: assert property (@(posedge clk)
    $past(rst) |-> (led_o == 8'h33 || led_o == 8'h01 ||
                    led_o == 8'h80 || led_o == 8'h81));
endmodule

// File: tb/led_pattern_seq_tb_top.sv
module led_pattern_seq_tb_top;
  localparam int W   = 4;
  localparam int PER = 1 << W;
  localparam int NV  = 24;
  // {mode, expected LED after the following step}
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 8'h33}, {2'd0, 8'hCC}, {2'd1, 8'h01}, {2'd1, 8'h02},
    {2'd1, 8'h04}, {2'd1, 8'h08}, {2'd1, 8'h10}, {2'd1, 8'h20},
    {2'd1, 8'h40}, {2'd1, 8'h80}, {2'd1, 8'h01}, {2'd2, 8'h80},
    {2'd2, 8'h40}, {2'd2, 8'h20}, {2'd2, 8'h10}, {2'd2, 8'h08},
    {2'd2, 8'h04}, {2'd2, 8'h02}, {2'd2, 8'h01}, {2'd2, 8'h80},
    {2'd3, 8'h81}, {2'd3, 8'h18}, {2'd3, 8'h81}, {2'd0, 8'h33}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [7:0] led;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  led_pattern_seq #(.PRESCALE_W(W)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode),
    .led_o  (led)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (led !== exp) begin
      errors++;
      $display("FAIL %s: led=%h expected=%h", req, led, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: led=%h expected=done", led);
      finish_run();
    end
  end

  initial begin
    edges(2);
    chk("R1 reset mode00", 8'h33);
    rst = 1'b0;
    edges(PER / 2);
    chk("R2 no early step", 8'h33);
    edges(1);
    chk("R2 first step / R3", 8'hCC);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][9:8];
      edges(PER);
      chk($sformatf("R3-R8 vector %0d", i), VEC[i][7:0]);
    end

    // R8: mid-period change is held until the step
    edges(PER / 2);
    mode = 2'd1;
    edges(1);
    chk("R8 hold mid-period", 8'h33);
    edges(PER / 2 - 1);
    chk("R8 restart at step", 8'h01);

    // R8: change undone before the step has no effect
    edges(4);
    mode = 2'd3;
    edges(4);
    chk("R8 hold after change", 8'h01);
    mode = 2'd1;
    edges(PER - 8);
    chk("R8 undone change", 8'h02);

    // R1, R2: reset mid-run in mode 11
    mode = 2'd3;
    rst = 1'b1;
    edges(2);
    chk("R1 reset mode11", 8'h81);
    rst = 1'b0;
    edges(PER / 2);
    chk("R2 hold after reset", 8'h81);
    edges(1);
    chk("R6 step after reset", 8'h18);

    // R1, R5: reset in mode 10
    mode = 2'd2;
    rst = 1'b1;
    edges(2);
    chk("R1 reset mode10", 8'h80);
    rst = 1'b0;
    edges(PER / 2 + 1);
    chk("R5 first walk step", 8'h40);

    done = 1'b1;
    finish_run();
  end
endmodule